// File: doc/BRIEF.md
# Sticky Event Flag and Interrupt Mask Controller

This block gathers six event sources of a timekeeping unit into sticky status flags and combines them with a software-owned mask into one active-high interrupt request. Single-cycle event pulses set their flags. A level input, high while the free-running time/date counters hold invalid values, keeps the error flag set for as long as the condition lasts.

Software reaches the block through three write-only command ports and two read ports. Each command port is a write strobe plus a 6-bit data word. The clear port drops status flags. The enable port sets mask bits and the disable port drops them. Every write is write-one-to-act, and zero bits do nothing. The status and mask vectors are read directly. Bus decode is outside the block: whatever sits above it turns register accesses into these strobes.

Top module: `event_flag_irq`

## Requirements
- R1: Every 6-bit vector (status, clear, enable, disable, mask, event) uses one bit order: bit 0 update acknowledge, bit 1 alarm, bit 2 second event, bit 3 time event, bit 4 calendar event, bit 5 time/date error.
- R2: An event pulse on bit i sets status bit i at the next rising clock edge. The bit then stays at 1 until it is cleared.
- R3: A clear write with bit i at 1 drops status bit i at the next edge. Bits written as 0 leave their flags unchanged.
- R4: When an event on bit i arrives in the same cycle as a clear of bit i, the event wins and the flag reads 1 afterwards.
- R5: While the invalid-time/date level is high, status bit 5 is set at the next edge and cannot be cleared. Once the level is low, a clear of bit 5 drops it.
- R6: An enable write with bit i at 1 sets mask bit i. A disable write with bit i at 1 drops mask bit i. Zero bits in either write leave the mask unchanged.
- R7: When enable and disable writes target the same bit in one cycle, the mask bit ends at 0.
- R8: The interrupt output is high exactly when some status bit and its mask bit are both 1. It falls in the cycle after the edge that clears the last pending enabled flag.
- R9: Reset (active low, asynchronous) forces all status and mask bits and the interrupt output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evtPulse | input | 6 | One-cycle event pulses, bit order of R1 |
| tdInvalid | input | 1 | High while the time/date counters hold invalid values |
| clrWe | input | 1 | Clear-status write strobe |
| clrData | input | 6 | Clear-status data, write-one-to-clear |
| enWe | input | 1 | Interrupt-enable write strobe |
| enData | input | 6 | Interrupt-enable data, write-one-to-set |
| disWe | input | 1 | Interrupt-disable write strobe |
| disData | input | 6 | Interrupt-disable data, write-one-to-clear |
| statusQ | output | 6 | Sticky status flags |
| maskQ | output | 6 | Interrupt mask |
| irq | output | 1 | Active-high interrupt request |

## Verification
On every cycle, the assertions check the following:
- an event always leaves its flag set;
- no flag rises without an event or the invalid level;
- a clear without competing events empties the cleared bits;
- the invalid level pins the error flag;
- a disable always wins over an enable.

Other behaviours need the bench's ordered scenarios. These include:
- the exact bit mapping of each source;
- a zero-data write having no effect;
- the error flag becoming clearable only after the level drops;
- the interrupt falling precisely one cycle after the last enabled flag is cleared, while masked flags stay pending.

// File: rtl/event_flag_pkg.sv
package event_flag_pkg;
  localparam int SRC_COUNT = 6;

  localparam int IDX_ACK   = 0;
  localparam int IDX_ALARM = 1;
  localparam int IDX_SEC   = 2;
  localparam int IDX_TIME  = 3;
  localparam int IDX_CAL   = 4;
  localparam int IDX_TDERR = 5;

  typedef logic [SRC_COUNT-1:0] srcVec_t;

  // Gated strobes from control to datapath
  typedef struct packed {
    srcVec_t clrBits;
    srcVec_t setMask;
    srcVec_t dropMask;
  } strobe_t;
endpackage

// File: rtl/event_flag_ctrl.sv
module event_flag_ctrl
  import event_flag_pkg::*;
(
  input  logic    clrWe,
  input  srcVec_t clrData,
  input  logic    enWe,
  input  srcVec_t enData,
  input  logic    disWe,
  input  srcVec_t disData,
  input  srcVec_t statusQ,
  input  srcVec_t maskQ,
  output strobe_t strobes,
  output logic    irq
);
  always_comb begin
    strobes.clrBits  = clrWe ? clrData : '0;
    strobes.setMask  = enWe  ? enData  : '0;
    strobes.dropMask = disWe ? disData : '0;
  end

  assign irq = |(statusQ & maskQ);
endmodule

// File: rtl/event_flag_datapath.sv
module event_flag_datapath
  import event_flag_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  strobe_t strobes,
  input  srcVec_t evtPulse,
  input  logic    tdInvalid,
  output srcVec_t statusQ,
  output srcVec_t maskQ
);
  srcVec_t holdVec;
  srcVec_t statusNext;
  srcVec_t maskNext;

  always_comb begin
    holdVec = '0;
    holdVec[IDX_TDERR] = tdInvalid;
    // set terms listed last so an event beats a clear (R4, R5)
    statusNext = (statusQ & ~strobes.clrBits) | evtPulse | holdVec;
    // drop applied after set so a disable wins (R7)
    maskNext = (maskQ | strobes.setMask) & ~strobes.dropMask;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ <= '0;
      maskQ   <= '0;
    end else begin
      statusQ <= statusNext;
      maskQ   <= maskNext;
    end
  end

  p_event_sets_r2: assert property (@(posedge clk) disable iff (!rstN)
    (|evtPulse) |=> ((statusQ & $past(evtPulse)) == $past(evtPulse)));

  p_no_spurious_set_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!(|evtPulse) && !tdInvalid) |=> ((statusQ & ~$past(statusQ)) == '0));

  p_clear_empties_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!(|evtPulse) && !tdInvalid) |=> ((statusQ & $past(strobes.clrBits)) == '0));

  p_err_held_r5: assert property (@(posedge clk) disable iff (!rstN)
    tdInvalid |=> statusQ[IDX_TDERR]);

  p_disable_wins_r7: assert property (@(posedge clk) disable iff (!rstN)
    (|strobes.dropMask) |=> ((maskQ & $past(strobes.dropMask)) == '0));

  p_enable_sets_r6: assert property (@(posedge clk) disable iff (!rstN)
    (|strobes.setMask) |=>
      ((maskQ & $past(strobes.setMask & ~strobes.dropMask))
        == $past(strobes.setMask & ~strobes.dropMask)));
endmodule

// File: rtl/event_flag_irq.sv
module event_flag_irq
  import event_flag_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [SRC_COUNT-1:0] evtPulse,
  input  logic                 tdInvalid,
  input  logic                 clrWe,
  input  logic [SRC_COUNT-1:0] clrData,
  input  logic                 enWe,
  input  logic [SRC_COUNT-1:0] enData,
  input  logic                 disWe,
  input  logic [SRC_COUNT-1:0] disData,
  output logic [SRC_COUNT-1:0] statusQ,
  output logic [SRC_COUNT-1:0] maskQ,
  output logic                 irq
);
  strobe_t strobes;

  event_flag_ctrl u_ctrl (
    .clrWe   (clrWe),
    .clrData (clrData),
    .enWe    (enWe),
    .enData  (enData),
    .disWe   (disWe),
    .disData (disData),
    .statusQ (statusQ),
    .maskQ   (maskQ),
    .strobes (strobes),
    .irq     (irq)
  );

  event_flag_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .evtPulse  (evtPulse),
    .tdInvalid (tdInvalid),
    .statusQ   (statusQ),
    .maskQ     (maskQ)
  );

  p_irq_needs_mask_r8: assert property (@(posedge clk) disable iff (!rstN)
    (maskQ == '0) |-> !irq);
endmodule

// File: tb/event_flag_irq_tb.sv
`timescale 1ns/100ps
module event_flag_irq_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [5:0] evtPulse = '0;
  logic       tdInvalid = 1'b0;
  logic       clrWe = 1'b0;
  logic [5:0] clrData = '0;
  logic       enWe = 1'b0;
  logic [5:0] enData = '0;
  logic       disWe = 1'b0;
  logic [5:0] disData = '0;
  logic [5:0] statusQ;
  logic [5:0] maskQ;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  event_flag_irq u_dut (
    .clk(clk), .rstN(rstN), .evtPulse(evtPulse), .tdInvalid(tdInvalid),
    .clrWe(clrWe), .clrData(clrData), .enWe(enWe), .enData(enData),
    .disWe(disWe), .disData(disData), .statusQ(statusQ), .maskQ(maskQ), .irq(irq)
  );

  typedef struct packed {
    logic [15:0] tag;
    logic [5:0]  evt;
    logic        inv;
    logic        cWe;
    logic [5:0]  cDat;
    logic        eWe;
    logic [5:0]  eDat;
    logic        dWe;
    logic [5:0]  dDat;
    logic [5:0]  expSt;
    logic [5:0]  expMk;
    logic        expIrq;
  } vec_t;

  localparam int NVEC = 16;
  localparam vec_t VECS [NVEC] = '{
    '{"R1", 6'h01, 1'b0, 1'b0, 6'h00, 1'b0, 6'h00, 1'b0, 6'h00, 6'h01, 6'h00, 1'b0},
    '{"R6", 6'h00, 1'b0, 1'b0, 6'h00, 1'b1, 6'h03, 1'b0, 6'h00, 6'h01, 6'h03, 1'b1},
    '{"R2", 6'h02, 1'b0, 1'b0, 6'h00, 1'b0, 6'h00, 1'b0, 6'h00, 6'h03, 6'h03, 1'b1},
    '{"R3", 6'h00, 1'b0, 1'b1, 6'h01, 1'b0, 6'h00, 1'b0, 6'h00, 6'h02, 6'h03, 1'b1},
    '{"R3", 6'h00, 1'b0, 1'b1, 6'h00, 1'b0, 6'h00, 1'b0, 6'h00, 6'h02, 6'h03, 1'b1},
    '{"R8", 6'h00, 1'b0, 1'b1, 6'h02, 1'b0, 6'h00, 1'b0, 6'h00, 6'h00, 6'h03, 1'b0},
    '{"R4", 6'h04, 1'b0, 1'b1, 6'h04, 1'b0, 6'h00, 1'b0, 6'h00, 6'h04, 6'h03, 1'b0},
    '{"R7", 6'h00, 1'b0, 1'b0, 6'h00, 1'b1, 6'h3C, 1'b1, 6'h04, 6'h04, 6'h3B, 1'b0},
    '{"R5", 6'h00, 1'b1, 1'b0, 6'h00, 1'b0, 6'h00, 1'b0, 6'h00, 6'h24, 6'h3B, 1'b1},
    '{"R5", 6'h00, 1'b1, 1'b1, 6'h24, 1'b0, 6'h00, 1'b0, 6'h00, 6'h20, 6'h3B, 1'b1},
    '{"R5", 6'h00, 1'b0, 1'b1, 6'h20, 1'b0, 6'h00, 1'b0, 6'h00, 6'h00, 6'h3B, 1'b0},
    '{"R6", 6'h00, 1'b0, 1'b0, 6'h00, 1'b0, 6'h00, 1'b1, 6'h3F, 6'h00, 6'h00, 1'b0},
    '{"R1", 6'h3F, 1'b0, 1'b0, 6'h00, 1'b0, 6'h00, 1'b0, 6'h00, 6'h3F, 6'h00, 1'b0},
    '{"R8", 6'h00, 1'b0, 1'b0, 6'h00, 1'b1, 6'h08, 1'b0, 6'h00, 6'h3F, 6'h08, 1'b1},
    '{"R6", 6'h00, 1'b0, 1'b0, 6'h00, 1'b1, 6'h00, 1'b1, 6'h00, 6'h3F, 6'h08, 1'b1},
    '{"R8", 6'h00, 1'b0, 1'b1, 6'h08, 1'b0, 6'h00, 1'b0, 6'h00, 6'h37, 6'h08, 1'b0}
  };

  task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    evtPulse = '0; tdInvalid = 1'b0; clrWe = 1'b0; clrData = '0;
    enWe = 1'b0; enData = '0; disWe = 1'b0; disData = '0;
  endtask

  task automatic apply(input vec_t v);
    evtPulse = v.evt; tdInvalid = v.inv; clrWe = v.cWe; clrData = v.cDat;
    enWe = v.eWe; enData = v.eDat; disWe = v.dWe; disData = v.dDat;
    @(negedge clk);
    idle();
  endtask

  task automatic finish();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9", statusQ, 6'h00, "status in reset");
    check("R9", maskQ, 6'h00, "mask in reset");
    check("R9", {5'b0, irq}, 6'h00, "irq in reset");
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      vec_t v;
      v = VECS[i];
      apply(v);
      check(string'(v.tag), statusQ, v.expSt, $sformatf("status row %0d", i));
      check(string'(v.tag), maskQ, v.expMk, $sformatf("mask row %0d", i));
      check(string'(v.tag), {5'b0, irq}, {5'b0, v.expIrq}, $sformatf("irq row %0d", i));
    end

    // R2: sticky flag persists over idle cycles
    repeat (4) @(negedge clk);
    check("R2", statusQ, 6'h37, "status held while idle");

    // R5: invalid level alone sets error flag, kept over several clears
    idle(); apply('{"R5", 6'h00, 1'b0, 1'b1, 6'h3F, 1'b0, 6'h00, 1'b0, 6'h00, 6'h00, 6'h08, 1'b0});
    check("R5", statusQ, 6'h00, "all cleared");
    tdInvalid = 1'b1;
    @(negedge clk);
    check("R5", statusQ, 6'h20, "error set by level");
    for (int k = 0; k < 3; k++) begin
      clrWe = 1'b1; clrData = 6'h20;
      @(negedge clk);
      check("R5", statusQ, 6'h20, "error held during clear");
    end
    tdInvalid = 1'b0; clrWe = 1'b0;
    @(negedge clk);
    check("R5", statusQ, 6'h20, "error remains after level drop");
    clrWe = 1'b1; clrData = 6'h20;
    @(negedge clk);
    idle();
    check("R5", statusQ, 6'h00, "error clearable after drop");

    // R8: irq rises one edge after enabled event, masked event does not assert
    enWe = 1'b1; enData = 6'h02;
    @(negedge clk);
    idle();
    evtPulse = 6'h01;
    @(negedge clk);
    idle();
    check("R8", {5'b0, irq}, 6'h00, "masked event no irq");
    evtPulse = 6'h02;
    @(negedge clk);
    idle();
    check("R8", {5'b0, irq}, 6'h01, "enabled event irq");

    // R9: mid-run reset clears everything
    rstN = 1'b0;
    @(negedge clk);
    check("R9", statusQ, 6'h00, "status after reset");
    check("R9", maskQ, 6'h00, "mask after reset");
    check("R9", {5'b0, irq}, 6'h00, "irq after reset");
    rstN = 1'b1;
    @(negedge clk);
    finish();
  end
endmodule